// File: doc/BRIEF.md
# Indirect Table Access Engine

This block gives software a way into a set of small internal configuration tables through just two registers. The pointer register holds a table selector, an entry index and an auto-advance flag. The window register reaches the entry that the pointer names. Before use, the index is clipped to the selected table's size with a per-table mask. When auto-advance is set, every window access steps the index forward and wraps it inside that mask. Filling or dumping a whole table therefore takes one pointer write followed by a burst of window accesses.

Some selectors are accepted but have no backing storage. They read as zero, drop writes and still advance the index. Selectors outside the known set do four things: raise a one-cycle error, read as zero, leave the pointer untouched and change no table. Two tables need downstream action on every write: the interrupt-routing table and the wide-window table. For these the block emits a one-cycle strobe carrying the table, the entry and the value. Interrupt-routing entries are filtered to their meaningful fields on the way in. Their routing target is passed downstream with its two low link bits dropped.

Accesses are single-cycle requests. The read response, the error pulse and the side-effect strobe all appear exactly one clock after the request.

Top module: `itab_engine`

## Requirements
- R1: After reset the pointer register is 0, every stored entry reads 0, and rsp_valid, err and fx_valid are low.
- R2: Writing the pointer (acc_tgt=0) keeps only bit 31 (auto-advance), bits 19:16 (selector) and bits 11:0 (index). Every other bit reads back as 0.
- R3: A read (acc_wr=0) raises rsp_valid for exactly the following cycle. On that cycle rsp_data holds either the pointer (acc_tgt=0) or the entry at the masked pre-advance index (acc_tgt=1). rsp_valid is low after every other cycle.
- R4: A window write stores acc_wdata into entry (index AND mask) of the selected table. A later read of that entry returns the stored value.
- R5: After a window access with auto-advance set, the pointer index field becomes ((index AND mask)+1) AND mask. With auto-advance clear, the index field is left unchanged.
- R6: The masks by selector are: 0→3, 1→7, 2→7, 3→31, 4→63, 5→511, 6→15, 7→255, 8→255.
- R7: Selectors 3, 4 and 8 have no storage. They read 0 and discard writes, and auto-advance still applies to them.
- R8: A window access with a selector from 9 to 15 behaves as follows. err is high for the next cycle, with rsp_data 0 and fx_valid low. The pointer is unchanged, and no table is written.
- R9: A write to selector 1 (interrupt routing) keeps only bits 19:0 of the data. Within those bits, 15:8 is the routing target, 7:0 the priority and 19:16 the node.
- R10: A window write to selector 1 or 6 raises fx_valid for the next cycle, with fx_table = selector and fx_index = masked index. For selector 6, fx_data is the written value. For selector 1, fx_data is the filtered value with bits 15:8 replaced by the target shifted right by 2.
- R11: No write to any other selector raises fx_valid, and a read never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_tgt | input | 1 | 0 = pointer register, 1 = window register |
| acc_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | DATA_W | Read response data |
| err | output | 1 | Unknown selector used in a window access |
| fx_valid | output | 1 | Side-effect strobe |
| fx_table | output | SEL_W | Table of the side-effect write |
| fx_index | output | IDX_W | Entry of the side-effect write |
| fx_data | output | DATA_W | Value passed downstream |

## Verification
A wrong mask or a bad base offset in the flat storage shows up on the next window read, one cycle after the request. The data comes back from a neighbouring table's entry or from the wrong entry of the same table. A faulty advance shows on the next pointer read as an index outside the mask or one that failed to wrap. Burst stimulus that walks past the top of each table catches both faults within a few accesses. A missed error or a missed strobe is visible in the single cycle after the offending write.

// File: rtl/itab_engine.sv
module itab_engine #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 12,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_tgt,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              err,
  output logic              fx_valid,
  output logic [SEL_W-1:0]  fx_table,
  output logic [IDX_W-1:0]  fx_index,
  output logic [DATA_W-1:0] fx_data
);

  localparam int PTR_W    = 32;
  localparam int SEL_LSB  = 16;
  localparam int AUTO_BIT = 31;

  localparam int MASK_ERRV = 3;
  localparam int MASK_IRQ  = 7;
  localparam int MASK_LIST = 7;
  localparam int MASK_NS0  = 31;
  localparam int MASK_NS1  = 63;
  localparam int MASK_XLT  = 511;
  localparam int MASK_WIDE = 15;
  localparam int MASK_NARW = 255;
  localparam int MASK_NS2  = 255;

  localparam int BASE_ERRV = 0;
  localparam int BASE_IRQ  = BASE_ERRV + MASK_ERRV + 1;
  localparam int BASE_LIST = BASE_IRQ + MASK_IRQ + 1;
  localparam int BASE_XLT  = BASE_LIST + MASK_LIST + 1;
  localparam int BASE_WIDE = BASE_XLT + MASK_XLT + 1;
  localparam int BASE_NARW = BASE_WIDE + MASK_WIDE + 1;
  localparam int TOTAL     = BASE_NARW + MASK_NARW + 1;
  localparam int FLAT_W    = $clog2(TOTAL);

  localparam logic [SEL_W-1:0] TBL_IRQ  = SEL_W'(1);
  localparam logic [SEL_W-1:0] TBL_WIDE = SEL_W'(6);
  localparam logic [SEL_W-1:0] TBL_LAST = SEL_W'(8);

  localparam logic [PTR_W-1:0]  PTR_KEEP = (PTR_W'(1) << AUTO_BIT)
                                         | (PTR_W'((1 << SEL_W) - 1) << SEL_LSB)
                                         | PTR_W'((1 << IDX_W) - 1);
  localparam logic [DATA_W-1:0] IRQ_KEEP = DATA_W'(20'hFFFFF);

  function automatic logic [IDX_W-1:0] tbl_mask(input logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(0): tbl_mask = IDX_W'(MASK_ERRV);
      SEL_W'(1): tbl_mask = IDX_W'(MASK_IRQ);
      SEL_W'(2): tbl_mask = IDX_W'(MASK_LIST);
      SEL_W'(3): tbl_mask = IDX_W'(MASK_NS0);
      SEL_W'(4): tbl_mask = IDX_W'(MASK_NS1);
      SEL_W'(5): tbl_mask = IDX_W'(MASK_XLT);
      SEL_W'(6): tbl_mask = IDX_W'(MASK_WIDE);
      SEL_W'(7): tbl_mask = IDX_W'(MASK_NARW);
      SEL_W'(8): tbl_mask = IDX_W'(MASK_NS2);
      default:   tbl_mask = '0;
    endcase
  endfunction

  function automatic logic tbl_stored(input logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(0), SEL_W'(1), SEL_W'(2), SEL_W'(5), SEL_W'(6), SEL_W'(7): tbl_stored = 1'b1;
      default: tbl_stored = 1'b0;
    endcase
  endfunction

  function automatic logic [FLAT_W-1:0] tbl_base(input logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(1): tbl_base = FLAT_W'(BASE_IRQ);
      SEL_W'(2): tbl_base = FLAT_W'(BASE_LIST);
      SEL_W'(5): tbl_base = FLAT_W'(BASE_XLT);
      SEL_W'(6): tbl_base = FLAT_W'(BASE_WIDE);
      SEL_W'(7): tbl_base = FLAT_W'(BASE_NARW);
      default:   tbl_base = FLAT_W'(BASE_ERRV);
    endcase
  endfunction

  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] store_q [TOTAL];

  logic [SEL_W-1:0]  sel;
  logic [IDX_W-1:0]  mask, idx, idx_next;
  logic              known, stored, auto_adv;
  logic              win_acc, bad_acc, fx_hit;
  logic [FLAT_W-1:0] slot;
  logic [DATA_W-1:0] wr_val, rd_val, fx_val;

  assign sel      = ptr_q[SEL_LSB +: SEL_W];
  assign auto_adv = ptr_q[AUTO_BIT];
  assign known    = (sel <= TBL_LAST);
  assign stored   = tbl_stored(sel);
  assign mask     = tbl_mask(sel);
  assign idx      = ptr_q[IDX_W-1:0] & mask;
  assign idx_next = (idx + IDX_W'(1)) & mask;
  assign slot     = tbl_base(sel) + FLAT_W'(idx);

  assign win_acc  = acc_en && acc_tgt;
  assign bad_acc  = win_acc && !known;
  assign fx_hit   = win_acc && acc_wr && (sel == TBL_IRQ || sel == TBL_WIDE);

  assign wr_val   = (sel == TBL_IRQ) ? (acc_wdata & IRQ_KEEP) : acc_wdata;
  assign rd_val   = stored ? store_q[slot] : '0;
  assign fx_val   = (sel == TBL_IRQ)
                  ? {wr_val[DATA_W-1:16], 2'b00, wr_val[15:10], wr_val[7:0]}
                  : wr_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < TOTAL; i++) store_q[i] <= '0;
    end else if (acc_en) begin
      if (!acc_tgt) begin
        if (acc_wr) ptr_q <= acc_wdata[PTR_W-1:0] & PTR_KEEP;
      end else if (known) begin
        if (acc_wr && stored) store_q[slot] <= wr_val;
        if (auto_adv) ptr_q[IDX_W-1:0] <= idx_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      err       <= 1'b0;
      fx_valid  <= 1'b0;
      fx_table  <= '0;
      fx_index  <= '0;
      fx_data   <= '0;
    end else begin
      rsp_valid <= acc_en && !acc_wr;
      if (acc_en) rsp_data <= !acc_tgt ? DATA_W'(ptr_q) : (known ? rd_val : '0);
      err       <= bad_acc;
      fx_valid  <= fx_hit;
      if (fx_hit) begin
        fx_table <= sel;
        fx_index <= idx;
        fx_data  <= fx_val;
      end
    end
  end

  assert_rsp_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> rsp_valid);
  assert_rsp_only_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_wr) |=> !rsp_valid);
  assert_adv_within_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && known && auto_adv) |=> ((ptr_q[IDX_W-1:0] & ~$past(mask)) == '0));
  assert_bad_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_acc |=> ($stable(ptr_q) && err));
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!fx_valid && rsp_data == '0));
  assert_irq_fx_filtered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_valid && fx_table == TBL_IRQ) |-> (fx_data[DATA_W-1:20] == '0 && fx_data[15:14] == 2'b00));
  assert_fx_tables_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fx_valid |-> (fx_table == TBL_IRQ || fx_table == TBL_WIDE));

endmodule

// File: tb/itab_engine_bench.sv
module itab_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_tgt = 1'b0;
  logic [63:0] acc_wdata = '0;
  logic        rsp_valid, err, fx_valid;
  logic [63:0] rsp_data, fx_data;
  logic [3:0]  fx_table;
  logic [11:0] fx_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  itab_engine u_itab_engine (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_tgt(acc_tgt),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .err(err),
    .fx_valid(fx_valid), .fx_table(fx_table), .fx_index(fx_index), .fx_data(fx_data)
  );

  logic [63:0] m_tab [0:8][0:511];
  logic [31:0] m_ptr;

  function automatic logic [11:0] m_mask(input logic [3:0] s);
    case (s)
      0: return 12'd3;   1: return 12'd7;   2: return 12'd7;
      3: return 12'd31;  4: return 12'd63;  5: return 12'd511;
      6: return 12'd15;  7: return 12'd255; 8: return 12'd255;
      default: return 12'd0;
    endcase
  endfunction

  function automatic bit m_stored(input logic [3:0] s);
    return (s == 0 || s == 1 || s == 2 || s == 5 || s == 6 || s == 7);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit tgt, input logic [63:0] wd, input string tag);
    bit          e_rv, e_err, e_fx;
    logic [63:0] e_rd, e_fxd, v;
    logic [3:0]  s;
    logic [11:0] i;
    e_rv = !wr; e_err = 0; e_fx = 0; e_rd = '0; e_fxd = '0; i = '0;
    s = m_ptr[19:16];
    if (!tgt) begin
      if (!wr) e_rd = {32'h0, m_ptr};
      else m_ptr = wd[31:0] & 32'h800F_0FFF;
    end else if (s > 8) begin
      e_err = 1;
    end else begin
      i = m_ptr[11:0] & m_mask(s);
      if (wr) begin
        v = (s == 1) ? (wd & 64'hFFFFF) : wd;
        if (m_stored(s)) m_tab[s][i] = v;
        if (s == 1 || s == 6) begin
          e_fx = 1;
          e_fxd = (s == 1) ? {v[63:16], 2'b00, v[15:10], v[7:0]} : v;
        end
      end else begin
        e_rd = m_stored(s) ? m_tab[s][i] : '0;
      end
      if (m_ptr[31]) m_ptr[11:0] = (i + 12'd1) & m_mask(s);
    end
    acc_en = 1; acc_wr = wr; acc_tgt = tgt; acc_wdata = wd;
    @(negedge clk);
    acc_en = 0;
    chk(rsp_valid == e_rv, {tag, " R3 rsp_valid"}, 64'(rsp_valid), 64'(e_rv));
    if (e_rv) chk(rsp_data == e_rd, {tag, " rsp_data"}, rsp_data, e_rd);
    chk(err == e_err, {tag, " R8 err"}, 64'(err), 64'(e_err));
    chk(fx_valid == e_fx, {tag, " R10 R11 fx_valid"}, 64'(fx_valid), 64'(e_fx));
    if (e_fx) begin
      chk(fx_table == s, {tag, " R10 fx_table"}, 64'(fx_table), 64'(s));
      chk(fx_index == i, {tag, " R10 fx_index"}, 64'(fx_index), 64'(i));
      chk(fx_data == e_fxd, {tag, " R9 R10 fx_data"}, fx_data, e_fxd);
    end
  endtask

  function automatic logic [63:0] ptr_val(input bit a, input int s, input int i);
    return {32'h0, a, 11'h0, 4'(s), 4'h0, 12'(i)};
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int s = 0; s < 9; s++) for (int i = 0; i < 512; i++) m_tab[s][i] = '0;
    m_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !err && !fx_valid, "R1 outputs idle", {61'h0, rsp_valid, err, fx_valid}, 64'h0);
    access(0, 0, '0, "R1 ptr reset");
    access(0, 1, '0, "R1 entry reset");

    access(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 ptr write");
    access(0, 0, '0, "R2 ptr readback");

    for (int s = 0; s < 9; s++) begin
      access(1, 0, ptr_val(1, s, 12'hFFF), "R6 top idx");
      access(1, 1, 64'hA5A5_0000_0000_0000 | 64'(s), "R4 R6 top write");
      access(0, 0, '0, "R5 R6 wrap to zero");
      access(1, 0, ptr_val(1, s, 12'hFFF), "R6 top idx again");
      access(0, 1, '0, "R4 R6 top read");
      access(0, 0, '0, "R5 wrap after read");
    end

    access(1, 0, ptr_val(0, 5, 300), "R5 no advance");
    access(1, 1, 64'h1234_5678_9ABC_DEF0, "R4 xlt write");
    access(0, 1, '0, "R3 R4 xlt read");
    access(0, 0, '0, "R5 index held");

    access(1, 0, ptr_val(1, 3, 30), "R7 ns ptr");
    access(1, 1, 64'hDEAD, "R7 ns write");
    access(1, 0, ptr_val(1, 3, 30), "R7 ns ptr back");
    access(0, 1, '0, "R7 ns read zero");
    access(0, 0, '0, "R7 ns advanced");

    access(1, 0, ptr_val(1, 12, 5), "R8 bad ptr");
    access(1, 1, 64'h77, "R8 bad write");
    access(0, 1, '0, "R8 bad read");
    access(0, 0, '0, "R8 ptr unchanged");

    access(1, 0, ptr_val(0, 1, 2), "R9 irq ptr");
    access(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R9 irq write");
    access(0, 1, '0, "R9 irq filtered read");
    access(1, 0, ptr_val(0, 2, 1), "R11 list ptr");
    access(1, 1, 64'h55, "R11 list no strobe");

    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 99);
      if (op < 20) begin
        int s;
        s = ($urandom_range(0, 9) == 0) ? $urandom_range(9, 15) : $urandom_range(0, 8);
        access(1, 0, ptr_val($urandom_range(0, 3) != 0, s, $urandom_range(0, 4095)), "R2 rnd ptr");
      end else if (op < 27) access(0, 0, '0, "R5 rnd ptr read");
      else if (op < 62) access(1, 1, {$urandom, $urandom}, "R4 R7 rnd write");
      else access(0, 1, '0, "R3 R6 rnd read");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule